// File: doc/BRIEF.md
# Serial DMA Request Agent

This block is the expansion-agent side of a two-wire serial DMA channel protocol. Local devices present a vector of eight pending DMA channel requests. Whenever the effective vector changes, the agent sends it on the request line as one frame. A frame is a low start bit followed by one slot per channel, from channel 0 to channel 7. Each slot lasts exactly one clock and is high when that channel is requesting.

The agent also watches the grant line. When it sees a low start bit, it takes the next three clocks as a channel number, least significant bit first. It then raises a one-cycle grant strobe carrying that number. After a grant, the channel is left out of later frames until its local device withdraws the request. This stops the same channel from being requested again while it is being served.

Top module: `dma_ser_agent`

## Requirements
- R1: When no frame is in progress, the request line is high. A frame is a low start bit followed by eight one-clock slots for channels 0 to 7, in that order. The start bit appears on the first clock edge that sees a changed effective vector.
- R2: Slot k of a frame is high exactly when channel k was pending, and not masked, at the edge that started the frame.
- R3: A frame starts only when the effective vector (pending and not masked) differs from the last vector sent. After reset, the last vector sent counts as all zero, so a vector that changes back to zero also produces a frame, with every slot low.
- R4: A frame is never cut short. A vector change during a frame is sent in the next frame, and that frame's start bit follows the channel 7 slot with no gap.
- R5: The grant receiver ignores a high grant line. After a low start bit it samples exactly three more clocks as data bits and does not treat those data bits as start bits.
- R6: On the clock after the third data bit is sampled, the grant strobe is high for exactly one cycle. It carries the channel number built from the data bits, least significant bit first. For example, the bits 1,0,0 give channel 1 and the bits 0,1,1 give channel 6.
- R7: A granted channel is left out of frames while its pending input stays high. The mask clears once that input goes low.
- R8: A new grant start bit sent on the clock right after the third data bit of the previous grant is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_pend_i | input | 8 | Pending request per DMA channel |
| req_ser_o | output | 1 | Serial request line (high when idle) |
| gnt_ser_i | input | 1 | Serial grant line (high when idle) |
| gnt_vld_o | output | 1 | One-cycle grant strobe |
| gnt_chan_o | output | 3 | Granted channel number, valid with the strobe |

## Verification
The start bit of a frame is on the request line one edge after a changed vector is sampled. Slot k follows k+1 edges after that. The bench therefore drives each vector on a falling edge and reads the line on each of the next nine falling edges.

The grant strobe appears on the falling edge four edges after the start bit is driven. The bench checks that the strobe is low on the falling edges before that point and on the one after it.

A frame that follows a grant mask update is due two edges after the strobe. It may have to wait behind a frame already in progress, so the bench waits for that start bit within a short bound and then reads the slots at their exact offsets.

// File: rtl/dma_ser_pkg.sv
package dma_ser_pkg;
  localparam int unsigned NUM_CH = 8;
  localparam int unsigned CH_W   = $clog2(NUM_CH);
endpackage

// File: rtl/dma_req_tx.sv
module dma_req_tx #(
  parameter int unsigned NUM_CH = dma_ser_pkg::NUM_CH,
  localparam int unsigned SLOT_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] vec_i,
  output logic              ser_o
);
  logic              busy_q;
  logic [SLOT_W-1:0] slot_q;
  logic [NUM_CH-1:0] shift_q, last_q;
  logic              ser_q;
  logic              start;

  assign start = !busy_q && (vec_i != last_q);
  assign ser_o = ser_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      slot_q  <= '0;
      shift_q <= '0;
      last_q  <= '0;
      ser_q   <= 1'b1;
    end else if (start) begin
      ser_q   <= 1'b0;
      shift_q <= vec_i;
      last_q  <= vec_i;
      busy_q  <= 1'b1;
      slot_q  <= '0;
    end else if (busy_q) begin
      ser_q  <= shift_q[slot_q];
      slot_q <= slot_q + SLOT_W'(1);
      if (slot_q == SLOT_W'(NUM_CH-1)) busy_q <= 1'b0;
    end else begin
      ser_q <= 1'b1;
    end
  end

  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (!ser_o && busy_q)); // R1
  AST_FRAME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && slot_q != '0) |-> $stable(shift_q)); // R4
endmodule

// File: rtl/dma_gnt_rx.sv
module dma_gnt_rx #(
  parameter int unsigned CH_W = dma_ser_pkg::CH_W,
  localparam int unsigned CNT_W = (CH_W > 1) ? $clog2(CH_W) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ser_i,
  output logic            vld_o,
  output logic [CH_W-1:0] chan_o
);
  logic             rcv_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CH_W-1:0]  bits_q, chan_d, chan_q;
  logic             vld_q;

  always_comb begin
    chan_d = bits_q;
    chan_d[CH_W-1] = ser_i;  // last bit is the MSB, arriving now
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rcv_q  <= 1'b0;
      cnt_q  <= '0;
      bits_q <= '0;
      chan_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (!rcv_q) begin
        if (!ser_i) begin
          rcv_q <= 1'b1;
          cnt_q <= '0;
        end
      end else begin
        bits_q[cnt_q] <= ser_i;
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(CH_W-1)) begin
          rcv_q  <= 1'b0;
          vld_q  <= 1'b1;
          chan_q <= chan_d;
        end
      end
    end
  end

  assign vld_o  = vld_q;
  assign chan_o = chan_q;

  AST_STROBE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rcv_q |=> !vld_o); // R5
endmodule

// File: rtl/dma_ser_agent.sv
module dma_ser_agent #(
  parameter int unsigned NUM_CH = dma_ser_pkg::NUM_CH,
  localparam int unsigned CH_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] req_pend_i,
  output logic              req_ser_o,
  input  logic              gnt_ser_i,
  output logic              gnt_vld_o,
  output logic [CH_W-1:0]   gnt_chan_o
);
  logic [NUM_CH-1:0] mask_q, set_vec, eff_vec;

  assign set_vec = gnt_vld_o ? (NUM_CH'(1) << gnt_chan_o) : '0;
  assign eff_vec = req_pend_i & ~mask_q;

  // mask survives only while the local request stays up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= (mask_q | set_vec) & req_pend_i;
  end

  dma_req_tx #(.NUM_CH(NUM_CH)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vec_i  (eff_vec),
    .ser_o  (req_ser_o)
  );

  dma_gnt_rx #(.CH_W(CH_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ser_i  (gnt_ser_i),
    .vld_o  (gnt_vld_o),
    .chan_o (gnt_chan_o)
  );

  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_vld_o && req_pend_i[gnt_chan_o]) |=> mask_q[$past(gnt_chan_o)]); // R7
endmodule

// File: tb/dma_ser_agent_bench.sv
module dma_ser_agent_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [7:0] req_pend_i;
  logic       req_ser_o;
  logic       gnt_ser_i;
  logic       gnt_vld_o;
  logic [2:0] gnt_chan_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dma_ser_agent u_dma_ser_agent (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_pend_i(req_pend_i), .req_ser_o(req_ser_o),
    .gnt_ser_i(gnt_ser_i), .gnt_vld_o(gnt_vld_o), .gnt_chan_o(gnt_chan_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // collect start + 8 slots, one per falling edge; optional pend change after sample chg_at
  task automatic recv_frame(input int chg_at, input logic [7:0] chg_val, output logic [8:0] got);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk_i);
      got[i] = req_ser_o;
      if (i == chg_at) req_pend_i = chg_val;
    end
  endtask

  task automatic idle_high(input int n, input string req);
    bit ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (req_ser_o !== 1'b1) ok = 1'b0;
    end
    chk(ok, req, {31'd0, ok}, 32'd1);
  endtask

  // drives start + 3 bits; returns on the falling edge where the strobe is due
  task automatic drive_grant(input logic [2:0] ch, output bit early);
    early = 1'b0;
    gnt_ser_i = 1'b0;
    for (int b = 0; b < 3; b++) begin
      @(negedge clk_i);
      if (gnt_vld_o === 1'b1) early = 1'b1;
      gnt_ser_i = ch[b];
    end
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [8:0] got;
    bit early;
    int k;
    rst_ni = 1'b0; req_pend_i = '0; gnt_ser_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(req_ser_o === 1'b1 && gnt_vld_o === 1'b0, "R1 reset", {30'd0, req_ser_o, gnt_vld_o}, 32'h2);
    rst_ni = 1'b1;

    // R3: zero vector after reset sends nothing
    idle_high(12, "R3 no frame at reset");

    // R1 R2: exhaustive vector sweep, back-to-back frames
    for (int v = 1; v < 257; v++) begin
      req_pend_i = v[7:0];
      recv_frame(99, '0, got);
      chk(got === {v[7:0], 1'b0}, "R1 R2 frame", {23'd0, got}, {23'd0, v[7:0], 1'b0});
    end
    // last was v=256 -> 0x00 frame (R3 change to zero)
    idle_high(10, "R3 no change no frame");

    // R4: change mid-frame
    req_pend_i = 8'h0F;
    recv_frame(3, 8'hF0, got);
    chk(got === {8'h0F, 1'b0}, "R4 frame kept", {23'd0, got}, {23'd0, 8'h0F, 1'b0});
    recv_frame(99, '0, got);
    chk(got === {8'hF0, 1'b0}, "R4 follow-up frame", {23'd0, got}, {23'd0, 8'hF0, 1'b0});
    req_pend_i = 8'h00;
    recv_frame(99, '0, got);
    chk(got === 9'd0, "R3 zero frame", {23'd0, got}, 32'd0);

    // R5 R6: every channel
    for (int c = 0; c < 8; c++) begin
      drive_grant(c[2:0], early);
      chk(!early, "R6 no early strobe", {31'd0, early}, 32'd0);
      chk(gnt_vld_o === 1'b1 && gnt_chan_o === c[2:0], "R6 grant channel",
          {28'd0, gnt_vld_o, gnt_chan_o}, {28'd0, 1'b1, c[2:0]});
      gnt_ser_i = 1'b1;
      @(negedge clk_i);
      chk(gnt_vld_o === 1'b0, "R6 strobe one cycle", {31'd0, gnt_vld_o}, 32'd0);
    end

    // R5: idle high line and low data bits never start a grant
    early = 1'b0;
    drive_grant(3'd0, early);
    gnt_ser_i = 1'b1;
    k = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (gnt_vld_o === 1'b1) k++;
    end
    chk(k == 0, "R5 ignore after data zeros", k, 0);

    // R8: back-to-back grants 5 then 2
    drive_grant(3'd5, early);
    chk(gnt_vld_o === 1'b1 && gnt_chan_o === 3'd5, "R8 first grant", {28'd0, gnt_vld_o, gnt_chan_o}, 32'hD);
    drive_grant(3'd2, early);
    chk(gnt_vld_o === 1'b1 && gnt_chan_o === 3'd2, "R8 second grant", {28'd0, gnt_vld_o, gnt_chan_o}, 32'hA);
    gnt_ser_i = 1'b1;
    @(negedge clk_i);

    // R7: masking
    req_pend_i = 8'h42;
    recv_frame(99, '0, got);
    chk(got === {8'h42, 1'b0}, "R7 pre-grant frame", {23'd0, got}, {23'd0, 8'h42, 1'b0});
    drive_grant(3'd1, early);
    chk(gnt_vld_o === 1'b1 && gnt_chan_o === 3'd1, "R7 grant ch1", {28'd0, gnt_vld_o, gnt_chan_o}, 32'h9);
    gnt_ser_i = 1'b1;
    k = 0;
    while (k < 5) begin
      @(negedge clk_i);
      if (req_ser_o === 1'b0) break;
      k++;
    end
    chk(k < 5, "R7 masked frame started", k, 0);
    got[0] = 1'b0;
    for (int i = 1; i < 9; i++) begin
      @(negedge clk_i);
      got[i] = req_ser_o;
    end
    chk(got === {8'h40, 1'b0}, "R7 masked frame", {23'd0, got}, {23'd0, 8'h40, 1'b0});
    idle_high(10, "R7 mask holds");
    req_pend_i = 8'h40;
    idle_high(10, "R7 drop gives no frame");
    req_pend_i = 8'h42;
    recv_frame(99, '0, got);
    chk(got === {8'h42, 1'b0}, "R7 mask cleared", {23'd0, got}, {23'd0, 8'h42, 1'b0});

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule